// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a synchronous host request port to an asynchronous static RAM with a 16-bit data bus, an 18-bit word address and separate lower and upper byte strobes. The host presents a request with a read/write flag, address, write data and a two-bit byte enable. It holds the request until the block shows ready. The controller then runs one memory cycle and returns ready when the cycle time has elapsed. For a read it also returns the data with a single-cycle valid pulse.

All memory timing comes from counting system clocks. Each window (write strobe, write cycle, read access and bus release) is a nanosecond limit for the selected speed grade (55 or 70). The limit is divided by the clock period and rounded up. The data bus is split into an output value, an output enable and an input. The controller drives the bus only during write phases. When a write follows a read, the controller first waits one bus-release period, so that the memory has stopped driving the bus before the controller starts.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, ready is high, chip select 1 (active low) is high, chip select 2 (active high) is low, write enable, output enable and both byte strobes (all active low) are high, the bus output enable is low and read-valid is low.
- R2: An accepted write holds write enable low for exactly 12 consecutive cycles at the default 5000 ps clock and 70 grade, which is the rounded-up maximum of 60, 50 and 30 ns. Throughout that pulse chip select 1 is low, chip select 2 is high, the address equals the request address, the lower strobe is low only if byte enable bit 0 is 1 (data bits 7..0) and the upper strobe is low only if bit 1 is 1 (bits 15..8).
- R3: The bus output enable is high only in write phases, with the request's write data on the output, and never while output enable is low.
- R4: Ready drops the cycle after a request is accepted. A write with no bus release before it keeps ready low for 14 cycles (70 ns rounded up).
- R5: A read holds output enable low and write enable high for 14 cycles, with the request address and the strobes chosen by the byte enables. The read data is captured on the last of these cycles. Read-valid is high for exactly the one cycle in which ready returns.
- R6: A read byte lane whose enable bit is 0 returns zero in the read data.
- R7: A write whose preceding operation was a read first spends 5 cycles (25 ns rounded up) with chip select 1 high and the bus released before write enable falls. Ready is then low for 19 cycles in total.
- R8: A write whose preceding operation was a write has no release period: write enable falls in the first busy cycle.
- R9: A write with byte enable 00 keeps both byte strobes high, still keeps ready low for the full write time, and leaves memory contents unchanged.
- R10: A request raised while ready is low is ignored. No read is started for it and output enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, held until accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = bits 7..0 |
| host_rdy | output | 1 | High when a request can be accepted |
| host_rdata | output | 16 | Read data, lanes masked by enables |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Chip select 1, active low |
| mem_cs2 | output | 1 | Chip select 2, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The bench checks writes that follow reads against writes that follow writes. A design that skips the release gap would collide with the memory's output drivers, and one that always inserts the gap would lose five cycles on every write. It checks the strobe length, because rounding down or sizing the strobe from the pulse minimum alone would end the write before the address window is met. It reads with partial byte enables from a memory model that returns junk on disabled lanes, so a missing mask shows up in the read data. It also checks that an all-zero-enable write and a request raised during a busy cycle leave no trace at the memory pins.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_TURN   = 3'd1,
      S_WPULSE = 3'd2,
      S_WREC   = 3'd3,
      S_RACC   = 3'd4
   } seq_state_e;

   // nanoseconds to clock cycles, rounded up
   function automatic int cyc_ceil(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
   import asram_pkg::*;
#(
   parameter int PULSE_CYC = 12,
   parameter int REC_CYC   = 2,
   parameter int ACC_CYC   = 14,
   parameter int TURN_CYC  = 5,
   parameter int CNT_W     = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       wr,
   output logic       rdy,
   output seq_state_e st,
   output logic       load,
   output logic       rd_fire,
   output logic       cs1_n,
   output logic       cs2,
   output logic       we_n,
   output logic       oe_n
);

   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
   localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

   seq_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             after_rd_q;
   logic             cnt_zero;
   logic             chip_on;

   assign cnt_zero = (cnt_q == '0);
   assign load     = req && (st_q == S_IDLE);
   assign rd_fire  = (st_q == S_RACC) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         cnt_q      <= '0;
         after_rd_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (req) begin
                  if (wr) begin
                     after_rd_q <= 1'b0;
                     if (after_rd_q) begin
                        st_q  <= S_TURN;
                        cnt_q <= TURN_LD;
                     end else begin
                        st_q  <= S_WPULSE;
                        cnt_q <= PULSE_LD;
                     end
                  end else begin
                     st_q  <= S_RACC;
                     cnt_q <= ACC_LD;
                  end
               end
            end
            S_TURN: begin
               if (cnt_zero) begin
                  st_q  <= S_WPULSE;
                  cnt_q <= PULSE_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            S_WPULSE: begin
               if (cnt_zero) begin
                  st_q  <= S_WREC;
                  cnt_q <= REC_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            S_WREC: begin
               if (cnt_zero) st_q <= S_IDLE;
               else          cnt_q <= cnt_q - 1'b1;
            end
            S_RACC: begin
               if (cnt_zero) begin
                  st_q       <= S_IDLE;
                  after_rd_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign st      = st_q;
   assign rdy     = (st_q == S_IDLE);
   assign chip_on = (st_q == S_WPULSE) || (st_q == S_WREC) || (st_q == S_RACC);
   assign cs1_n   = !chip_on;
   assign cs2     = chip_on;
   assign we_n    = (st_q != S_WPULSE);
   assign oe_n    = (st_q != S_RACC);

   // length of the current write-enable low run
   logic [CNT_W-1:0] we_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     we_run_q <= '0;
      else if (!we_n) we_run_q <= we_run_q + 1'b1;
      else            we_run_q <= '0;
   end

   p_rdy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && rdy) |=> !rdy);
   p_we_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!cs1_n && cs2));
   p_we_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_run_q == CNT_W'(PULSE_CYC)));
   p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> we_n);

endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
module asram_lanes
   import asram_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANES-1:0]  be_in,
   input  seq_state_e        st,
   input  logic [DATA_W-1:0] raw_in,
   output logic [LANES-1:0]  lane_n,
   output logic [DATA_W-1:0] masked
);

   logic [LANES-1:0] be_q;
   logic             lanes_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    be_q <= '0;
      else if (load) be_q <= be_in;
   end

   assign lanes_on = (st == S_WPULSE) || (st == S_WREC) || (st == S_RACC);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g]          = !(be_q[g] && lanes_on);
      assign masked[g*8 +: 8]   = be_q[g] ? raw_in[g*8 +: 8] : 8'h00;
   end

   p_lanes_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> (&lane_n));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath
   import asram_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  seq_state_e        st,
   input  logic              rd_fire,
   input  logic [DATA_W-1:0] rd_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         addr_q  <= addr_in;
         wdata_q <= wdata_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_fire;
         if (rd_fire) rdata_q <= rd_in;
      end
   end

   assign mem_addr = addr_q;
   assign dq_o     = wdata_q;
   assign dq_oe    = (st == S_WPULSE) || (st == S_WREC);
   assign rdata    = rdata_q;
   assign rvalid   = rvalid_q;

   p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(mem_addr));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int SPEED_GRADE   = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [1:0]        host_be,
   output logic              host_rdy,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam bit FAST = (SPEED_GRADE == 55);
   localparam int NS_WC  = FAST ? 55 : 70;
   localparam int NS_WP  = FAST ? 40 : 50;
   localparam int NS_DW  = FAST ? 25 : 30;
   localparam int NS_AW  = FAST ? 50 : 60;
   localparam int NS_RC  = FAST ? 55 : 70;
   localparam int NS_AA  = FAST ? 55 : 70;
   localparam int NS_OE  = FAST ? 35 : 40;
   localparam int NS_HZ  = FAST ? 20 : 25;
   localparam int LANES  = DATA_W / 8;

   localparam int PULSE_CYC = max3(cyc_ceil(NS_WP, CLK_PERIOD_PS),
                                   cyc_ceil(NS_AW, CLK_PERIOD_PS),
                                   cyc_ceil(NS_DW, CLK_PERIOD_PS));
   localparam int WC_CYC    = cyc_ceil(NS_WC, CLK_PERIOD_PS);
   localparam int REC_CYC   = (WC_CYC > PULSE_CYC) ? (WC_CYC - PULSE_CYC) : 1;
   localparam int ACC_CYC   = max3(cyc_ceil(NS_RC, CLK_PERIOD_PS),
                                   cyc_ceil(NS_AA, CLK_PERIOD_PS),
                                   cyc_ceil(NS_OE, CLK_PERIOD_PS));
   localparam int TURN_CYC  = cyc_ceil(NS_HZ, CLK_PERIOD_PS);
   localparam int MAX_CYC   = max3(PULSE_CYC, ACC_CYC, max3(REC_CYC, TURN_CYC, 1));
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   initial begin
      a_grade_ok: assert (SPEED_GRADE == 55 || SPEED_GRADE == 70)
         else $error("speed grade must be 55 or 70");
      a_width_ok: assert (DATA_W == 16 && LANES == 2)
         else $error("two byte lanes of 8 bits required");
      a_period_ok: assert (CLK_PERIOD_PS > 0)
         else $error("clock period must be positive");
   end

   seq_state_e        st;
   logic              load;
   logic              rd_fire;
   logic [LANES-1:0]  lane_n;
   logic [DATA_W-1:0] rd_masked;

   asram_seq #(
      .PULSE_CYC (PULSE_CYC),
      .REC_CYC   (REC_CYC),
      .ACC_CYC   (ACC_CYC),
      .TURN_CYC  (TURN_CYC),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (host_req),
      .wr      (host_wr),
      .rdy     (host_rdy),
      .st      (st),
      .load    (load),
      .rd_fire (rd_fire),
      .cs1_n   (mem_cs1_n),
      .cs2     (mem_cs2),
      .we_n    (mem_we_n),
      .oe_n    (mem_oe_n)
   );

   asram_lanes #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .be_in  (host_be),
      .st     (st),
      .raw_in (mem_dq_i),
      .lane_n (lane_n),
      .masked (rd_masked)
   );

   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

   asram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .addr_in  (host_addr),
      .wdata_in (host_wdata),
      .st       (st),
      .rd_fire  (rd_fire),
      .rd_in    (rd_masked),
      .mem_addr (mem_addr),
      .dq_o     (mem_dq_o),
      .dq_oe    (mem_dq_oe),
      .rdata    (host_rdata),
      .rvalid   (host_rvalid)
   );

   // cycles since output enable was last low, saturating at the release time
   logic [CNT_W-1:0] oe_quiet_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              oe_quiet_q <= CNT_W'(TURN_CYC);
      else if (!mem_oe_n)                      oe_quiet_q <= '0;
      else if (oe_quiet_q < CNT_W'(TURN_CYC))  oe_quiet_q <= oe_quiet_q + 1'b1;
   end

   p_drive_no_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);
   p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_quiet_q >= CNT_W'(TURN_CYC)));

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

   localparam int WR_CYC   = 14;
   localparam int PULSE    = 12;
   localparam int RD_CYC   = 14;
   localparam int TURN     = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [17:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_be = '0;
   logic        host_rdy;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [17:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
   logic [15:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_i;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   bit prev_rd = 0;

   always #2.5 clk = ~clk;

   asram_ctrl i_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
      .host_rdy(host_rdy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
      .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   // device model: 256 words, indexed by the low address byte
   logic [15:0] dev_mem [0:255];
   logic [15:0] ref_mem [0:255];

   function automatic logic [15:0] init_word(input int i);
      return 16'(i * 16'h0101) ^ 16'h3C5A;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) dev_mem[i] <= init_word(i);
      end else if (!mem_we_n && !mem_cs1_n && mem_cs2) begin
         if (!mem_lb_n) dev_mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
         if (!mem_ub_n) dev_mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
      end
   end

   always_comb begin
      mem_dq_i = 16'hDEAD;
      if (!mem_oe_n && !mem_cs1_n && mem_cs2) begin
         mem_dq_i[7:0]  = mem_lb_n ? 8'hA5 : dev_mem[mem_addr[7:0]][7:0];
         mem_dq_i[15:8] = mem_ub_n ? 8'h5A : dev_mem[mem_addr[7:0]][15:8];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [17:0] a, input logic [1:0] be);
      logic [15:0] w;
      w = ref_mem[a[7:0]];
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   task automatic run_write(input logic [17:0] a, input logic [15:0] d,
                            input logic [1:0] be, input bit poke);
      int busy = 0, we_lo = 0, turn = 0, bad = 0, oe_seen = 0, lane_seen = 0;
      bit seen_we = 0;
      int exp_turn;
      exp_turn = prev_rd ? TURN : 0;
      @(negedge clk);
      host_req = 1; host_wr = 1; host_addr = a; host_wdata = d; host_be = be;
      @(posedge clk);
      #1 host_req = 0;
      while (busy < 200) begin
         @(negedge clk);
         if (host_rdy) break;
         busy++;
         if (poke && busy == 3) begin
            host_req = 1; host_wr = 0; host_addr = a ^ 18'h1; host_be = 2'b11;
         end
         if (poke && busy == 7) host_req = 0;
         if (!mem_oe_n) oe_seen++;
         if (!mem_lb_n || !mem_ub_n) lane_seen++;
         if (!mem_we_n) begin
            we_lo++;
            seen_we = 1;
            if (mem_dq_oe !== 1'b1 || mem_dq_o !== d || mem_addr !== a ||
                mem_lb_n !== !be[0] || mem_ub_n !== !be[1] ||
                mem_cs1_n !== 1'b0 || mem_cs2 !== 1'b1) bad++;
         end else if (!seen_we) begin
            if (mem_cs1_n && !mem_dq_oe) turn++;
         end
      end
      chk(busy == exp_turn + WR_CYC, "R4 write busy cycles", busy, exp_turn + WR_CYC);
      chk(we_lo == PULSE, "R2 write strobe length", we_lo, PULSE);
      chk(bad == 0, "R2 strobe, address, lanes, data during pulse", bad, 0);
      chk(oe_seen == 0, "R3 output enable low during write", oe_seen, 0);
      if (exp_turn != 0) chk(turn == exp_turn, "R7 release cycles before write", turn, exp_turn);
      else               chk(turn == 0, "R8 no release after write", turn, 0);
      if (be == 2'b00) chk(lane_seen == 0, "R9 byte strobes with zero enables", lane_seen, 0);
      if (be[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
      if (be[1]) ref_mem[a[7:0]][15:8] = d[15:8];
      prev_rd = 0;
   endtask

   task automatic run_read(input logic [17:0] a, input logic [1:0] be);
      int busy = 0, bad = 0, early = 0;
      logic [15:0] exp;
      exp = exp_read(a, be);
      @(negedge clk);
      host_req = 1; host_wr = 0; host_addr = a; host_be = be;
      @(posedge clk);
      #1 host_req = 0;
      while (busy < 200) begin
         @(negedge clk);
         if (host_rdy) break;
         busy++;
         if (host_rvalid) early++;
         if (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 || mem_dq_oe !== 1'b0 ||
             mem_addr !== a || mem_cs1_n !== 1'b0 || mem_cs2 !== 1'b1 ||
             mem_lb_n !== !be[0] || mem_ub_n !== !be[1]) bad++;
      end
      chk(busy == RD_CYC, "R5 read busy cycles", busy, RD_CYC);
      chk(bad == 0 && early == 0, "R5 read strobes and no early valid", bad + early, 0);
      chk(host_rvalid === 1'b1, "R5 read valid with ready", host_rvalid, 1);
      if (be != 2'b11) chk(host_rdata === exp, "R6 masked read data", host_rdata, exp);
      else             chk(host_rdata === exp, "R5 read data", host_rdata, exp);
      @(negedge clk);
      chk(host_rvalid === 1'b0, "R5 read valid single cycle", host_rvalid, 0);
      prev_rd = 1;
   endtask

   task automatic check_quiet(input int n);
      int oe_low = 0, valids = 0, busy = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!mem_oe_n) oe_low++;
         if (host_rvalid) valids++;
         if (!host_rdy) busy++;
      end
      chk(oe_low + valids + busy == 0, "R10 request while busy ignored",
          oe_low + valids + busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      chk(host_rdy === 1'b1 && mem_cs1_n === 1'b1 && mem_cs2 === 1'b0 &&
          mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_lb_n === 1'b1 &&
          mem_ub_n === 1'b1 && mem_dq_oe === 1'b0 && host_rvalid === 1'b0,
          "R1 reset state", {host_rdy, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n,
          mem_lb_n, mem_ub_n, mem_dq_oe, host_rvalid}, 9'b110111100);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(host_rdy === 1'b1 && mem_cs1_n === 1'b1 && mem_dq_oe === 1'b0,
          "R1 idle after reset", {host_rdy, mem_cs1_n, mem_dq_oe}, 3'b110);

      // directed corners
      run_write(18'h3FFFF, 16'hBEEF, 2'b11, 0);
      run_write(18'h00010, 16'h1234, 2'b11, 0);
      run_read (18'h3FFFF, 2'b11);
      run_write(18'h00010, 16'hAB55, 2'b01, 0);
      run_read (18'h00010, 2'b01);
      run_write(18'h00010, 16'h77CC, 2'b10, 0);
      run_read (18'h00010, 2'b11);
      run_write(18'h00020, 16'hFFFF, 2'b00, 0);
      run_read (18'h00020, 2'b11);
      run_read (18'h00020, 2'b00);
      run_write(18'h00030, 16'h0F0F, 2'b11, 1);
      check_quiet(20);
      run_read (18'h00030, 2'b10);

      // constrained random mix
      for (int n = 0; n < 80; n++) begin
         logic [17:0] a;
         logic [15:0] d;
         logic [1:0]  be;
         a  = 18'($urandom);
         d  = 16'($urandom);
         be = 2'($urandom);
         if ($urandom % 2) run_write(a, d, be, 0);
         else              run_read(a, be);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule